// File: doc/BRIEF.md
# Hash Final-Word Mask and Start Control

This block sits in front of a hash engine. It holds one memory-mapped control register through which software gives the number of valid bits in the final message word and requests the final digest. A write that sets the start bit produces a single-cycle start pulse for the hash core. The stored count is used to mask the last data word after that word has been reordered by a selectable swap stage. Only the low-order bits that the count allows reach the core.

Alongside the register, a word counter tracks how many 32-bit data words have arrived since the last initialisation. When the start pulse fires, the block presents the total message length in bits as a 64-bit value. An initialisation input clears the word counter and the stored count, so that a new message can begin.

Top module: `hash_final_ctrl`

## Requirements
- R1: After reset the start pulse is low, the valid-bit count is 0, the reported message length is 0 and the register reads as 0.
- R2: A write to offset 0x08 with bit 8 clear stores bits 4:0 as the valid-bit count. A read of offset 0x08 returns the count in bits 4:0 and 0 in every other bit. A read of any other offset returns 0.
- R3: A write to offset 0x08 with bit 8 set raises the start output for exactly one cycle, the cycle after the write. Bit 8 always reads as 0.
- R4: In a write to offset 0x08 that sets bit 8, bits 4:0 are ignored and the stored count keeps its previous value.
- R5: Writes to any offset other than 0x08 leave the stored count unchanged and raise no start pulse.
- R6: The last word strobed in passes through a swap stage whose mode input selects one of four orderings: 0 leaves the word unchanged, 1 exchanges the two 16-bit halves, 2 reverses the byte order, and 3 reverses the bit order.
- R7: The masked last word keeps all 32 swapped bits when the count is 0. For a count n from 1 to 31 it keeps swapped bits n-1..0 and forces the upper bits to 0.
- R8: At the start pulse, the length output equals 32 times the number of words strobed since initialisation, minus (32 - n) when the count n is nonzero. The value holds until the next start pulse.
- R9: The initialisation input clears the word counter and the stored count. A start pulse issued with no words since initialisation reports a length of 0.
- R10: The last-word output follows the most recent strobed word. It responds at once to a change of the swap mode or of the stored count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| init_i | input | 1 | Begins a new message: clears the word counter and the stored count |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Register write enable |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for the offset on bus_addr_i |
| din_valid_i | input | 1 | Strobe for one message data word |
| din_data_i | input | 32 | Message data word |
| swap_mode_i | input | 2 | Swap stage ordering (see R6) |
| last_word_o | output | 32 | Last strobed word, swapped and then masked |
| valid_bits_o | output | 5 | Stored valid-bit count |
| start_o | output | 1 | One-cycle request for the final digest |
| msg_len_o | output | 64 | Total message length in bits, captured at the start pulse |

## Verification
One asymmetric word is run through all four swap modes, so that each mode gives a distinct result and any exchange of modes shows up. Masking is tried with counts 0, 1, 8, 16 and 31, in combination with different swap modes. This separates masking done before the swap from masking done after it, and it exposes off-by-one errors at the mask boundary. Message lengths are scored for zero, one, two and three words with full and partial final words, which catches a wrong tail subtraction and a stale word count. Register writes are also tried with junk in the reserved bits, with the start bit and a count together, and at a wrong offset, to show which fields a write may touch.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CNT_W   = $clog2(WORD_W);
  localparam int unsigned LEN_W   = 64;

  typedef enum logic [1:0] {
    SWAP_NONE = 2'd0,
    SWAP_HALF = 2'd1,
    SWAP_BYTE = 2'd2,
    SWAP_BIT  = 2'd3
  } swap_mode_e;
endpackage

// File: rtl/hfc_ctrl_reg.sv
module hfc_ctrl_reg #(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  REG_OFFSET = 8'h08,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned START_BIT  = 8,
  parameter int unsigned CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              start_req_o,
  output logic              start_o
);
  logic             sel;
  logic             hit;
  logic             go;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;
  logic             start_q, start_nxt;

  assign sel = (addr_i == ADDR_W'(REG_OFFSET));
  assign hit = sel && we_i;
  assign go  = hit && wdata_i[START_BIT];

  always_comb begin
    cnt_nxt = cnt_q;
    cnt_en  = 1'b0;
    if (init_i) begin
      cnt_nxt = '0;
      cnt_en  = 1'b1;
    end else if (hit && !wdata_i[START_BIT]) begin
      cnt_nxt = wdata_i[CNT_W-1:0];
      cnt_en  = 1'b1;
    end
    start_nxt = go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_nxt;
      start_q <= start_nxt;
    end
  end

  assign rdata_o     = sel ? WORD_W'(cnt_q) : '0;
  assign cnt_o       = cnt_q;
  assign start_req_o = go;
  assign start_o     = start_q;

  // R4
  cnt_hold_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !init_i) |=> $stable(cnt_q));

  // R3
  start_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(go));
endmodule

// File: rtl/hfc_swap.sv
module hfc_swap #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  import hfc_pkg::*;

  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned N_BYTES = WORD_W / 8;

  logic [WORD_W-1:0] half_sw, byte_sw, bit_sw;

  assign half_sw = {word_i[HALF_W-1:0], word_i[WORD_W-1:HALF_W]};

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign byte_sw[8*b +: 8] = word_i[8*(N_BYTES-1-b) +: 8];
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign bit_sw[i] = word_i[WORD_W-1-i];
  end

  always_comb begin
    case (swap_mode_e'(mode_i))
      SWAP_HALF: word_o = half_sw;
      SWAP_BYTE: word_o = byte_sw;
      SWAP_BIT:  word_o = bit_sw;
      default:   word_o = word_i;
    endcase
  end

  // R6
  swap_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word_o) == $countones(word_i));
endmodule

// File: rtl/hfc_mask.sv
module hfc_mask #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic             full;
  logic [WORD_W-1:0] keep;

  assign full = (cnt_i == '0);

  for (genvar i = 0; i < WORD_W; i++) begin : g_keep
    assign keep[i] = full || (CNT_W'(i) < cnt_i);
  end

  assign word_o = word_i & keep;

  // R7
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i != '0) |-> ((word_o >> cnt_i) == '0));
endmodule

// File: rtl/hfc_len_cnt.sv
module hfc_len_cnt #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned WCNT_W = 32,
  parameter int unsigned LEN_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             strobe_i,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LEN_W-1:0] len_o
);
  logic [WCNT_W-1:0] wcnt_q, wcnt_nxt;
  logic              wcnt_en;
  logic [LEN_W-1:0]  len_q, len_calc;
  logic [LEN_W-1:0]  full_bits, tail_gap;

  always_comb begin
    wcnt_en  = init_i || strobe_i;
    wcnt_nxt = init_i ? '0 : wcnt_q + 1'b1;
  end

  assign full_bits = LEN_W'(wcnt_q) << CNT_W;
  assign tail_gap  = (cnt_i == '0) ? '0 : (LEN_W'(WORD_W) - LEN_W'(cnt_i));
  assign len_calc  = (wcnt_q == '0) ? '0 : (full_bits - tail_gap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      len_q  <= '0;
    end else begin
      if (wcnt_en)   wcnt_q <= wcnt_nxt;
      if (capture_i) len_q  <= len_calc;
    end
  end

  assign len_o = len_q;

  // R9
  init_clears_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (wcnt_q == '0));
endmodule

// File: rtl/hash_final_ctrl.sv
module hash_final_ctrl #(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  REG_OFFSET = 8'h08,
  parameter int unsigned START_BIT  = 8,
  parameter int unsigned WCNT_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         init_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic                         bus_we_i,
  input  logic [hfc_pkg::WORD_W-1:0]   bus_wdata_i,
  output logic [hfc_pkg::WORD_W-1:0]   bus_rdata_o,
  input  logic                         din_valid_i,
  input  logic [hfc_pkg::WORD_W-1:0]   din_data_i,
  input  logic [1:0]                   swap_mode_i,
  output logic [hfc_pkg::WORD_W-1:0]   last_word_o,
  output logic [hfc_pkg::CNT_W-1:0]    valid_bits_o,
  output logic                         start_o,
  output logic [hfc_pkg::LEN_W-1:0]    msg_len_o
);
  import hfc_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [WORD_W-1:0] raw_q;
  logic [WORD_W-1:0] swapped;
  logic [CNT_W-1:0]  cnt;
  logic              start_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)      raw_q <= '0;
    else if (din_valid_i) raw_q <= din_data_i;
  end

  hfc_ctrl_reg #(
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .WORD_W(WORD_W),
    .START_BIT(START_BIT), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_core_n), .init_i(init_i),
    .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .cnt_o(cnt),
    .start_req_o(start_req), .start_o(start_o)
  );

  hfc_swap #(.WORD_W(WORD_W)) i_swap (
    .clk(clk), .rst_n(rst_core_n), .mode_i(swap_mode_i),
    .word_i(raw_q), .word_o(swapped)
  );

  hfc_mask #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_mask (
    .clk(clk), .rst_n(rst_core_n), .cnt_i(cnt),
    .word_i(swapped), .word_o(last_word_o)
  );

  hfc_len_cnt #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .WCNT_W(WCNT_W), .LEN_W(LEN_W)
  ) i_len (
    .clk(clk), .rst_n(rst_core_n), .init_i(init_i),
    .strobe_i(din_valid_i), .capture_i(start_req), .cnt_i(cnt),
    .len_o(msg_len_o)
  );

  assign valid_bits_o = cnt;
endmodule

// File: tb/test_hash_final_ctrl.sv
`timescale 1ns/1ps
module test_hash_final_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        din_valid_i = 1'b0;
  logic [31:0] din_data_i = '0;
  logic [1:0]  swap_mode_i = '0;
  logic [31:0] last_word_o;
  logic [4:0]  valid_bits_o;
  logic        start_o;
  logic [63:0] msg_len_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  longint unsigned exp_q[$];
  string           tag_q[$];

  always #2.5 clk = ~clk;

  hash_final_ctrl i_hash_final_ctrl (
    .clk(clk), .rst_n(rst_n), .init_i(init_i),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .din_valid_i(din_valid_i), .din_data_i(din_data_i),
    .swap_mode_i(swap_mode_i), .last_word_o(last_word_o),
    .valid_bits_o(valid_bits_o), .start_o(start_o), .msg_len_o(msg_len_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev_bits(logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = d[i];
    return r;
  endfunction

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    bus_addr_i = a; bus_we_i = 1'b1; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a; #1; d = bus_rdata_o;
    @(negedge clk);
  endtask

  task automatic send_word(logic [31:0] d);
    din_valid_i = 1'b1; din_data_i = d;
    @(negedge clk);
    din_valid_i = 1'b0;
  endtask

  task automatic do_init();
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
  endtask

  // driver: push expected length then issue the start write
  task automatic start_digest(string tag, longint unsigned exp_len);
    exp_q.push_back(exp_len);
    tag_q.push_back(tag);
    reg_write(8'h08, 32'h0000_0100);
    @(negedge clk);
    check("R3 start one cycle", {63'd0, start_o}, 64'd0);
  endtask

  // monitor: compare length at each start pulse
  always @(negedge clk) begin
    if (start_o) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected start", 64'd1, 64'd0);
      end else begin
        check(tag_q.pop_front(), msg_len_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 start", {63'd0, start_o}, 64'd0);
    check("R1 count", {59'd0, valid_bits_o}, 64'd0);
    check("R1 length", msg_len_o, 64'd0);
    reg_read(8'h08, rd); check("R1 read", {32'd0, rd}, 64'd0);

    // R2 count write and readback, reserved bits read 0
    reg_write(8'h08, 32'h0000_0005);
    reg_read(8'h08, rd); check("R2 read 5", {32'd0, rd}, 64'h5);
    reg_write(8'h08, 32'hFFFF_FE0C);
    reg_read(8'h08, rd); check("R2 reserved zero", {32'd0, rd}, 64'hC);
    reg_read(8'h04, rd); check("R2 other offset", {32'd0, rd}, 64'd0);

    // R5 other offset write ignored
    reg_write(8'h04, 32'h0000_0107);
    @(negedge clk);
    reg_read(8'h08, rd); check("R5 count kept", {32'd0, rd}, 64'hC);

    // R4 start write with count field ignored; R3 bit 8 reads 0
    do_init();
    send_word(32'hAAAA_5555);
    reg_write(8'h08, 32'h0000_0003);
    start_digest("R8 one word n3", 64'd3);
    reg_write(8'h08, 32'h0000_0000);
    exp_q.push_back(64'd32); tag_q.push_back("R4 start kept n0");
    reg_write(8'h08, 32'h0000_0115);
    reg_read(8'h08, rd); check("R4 count unchanged", {32'd0, rd}, 64'h0);
    check("R3 bit8 reads 0", {63'd0, rd[8]}, 64'd0);

    // R6 swap modes, count 0 keeps full word
    send_word(32'h1234_5678);
    swap_mode_i = 2'd0; @(negedge clk); check("R6 none", {32'd0, last_word_o}, 64'h1234_5678);
    swap_mode_i = 2'd1; @(negedge clk); check("R6 half", {32'd0, last_word_o}, 64'h5678_1234);
    swap_mode_i = 2'd2; @(negedge clk); check("R6 byte", {32'd0, last_word_o}, 64'h7856_3412);
    swap_mode_i = 2'd3; @(negedge clk);
    check("R6 bit", {32'd0, last_word_o}, {32'd0, rev_bits(32'h1234_5678)});

    // R7 and R10 masking after swap, follows count changes
    swap_mode_i = 2'd2;
    reg_write(8'h08, 32'h0000_0008);
    check("R7 byte n8", {32'd0, last_word_o}, 64'h12);
    reg_write(8'h08, 32'h0000_0001);
    check("R7 n1", {32'd0, last_word_o}, 64'h0);
    swap_mode_i = 2'd1;
    reg_write(8'h08, 32'h0000_0010);
    check("R7 half n16", {32'd0, last_word_o}, 64'h1234);
    swap_mode_i = 2'd0;
    send_word(32'hFFFF_FFFF);
    reg_write(8'h08, 32'h0000_001F);
    check("R7 n31", {32'd0, last_word_o}, 64'h7FFF_FFFF);
    check("R10 count out", {59'd0, valid_bits_o}, 64'd31);
    send_word(32'hDEAD_BEEF);
    check("R10 newest word", {32'd0, last_word_o}, 64'h5EAD_BEEF);

    // R8 length scoreboard
    do_init();
    send_word(32'h1); send_word(32'h2); send_word(32'h3);
    start_digest("R8 three full", 64'd96);
    do_init();
    send_word(32'h1); send_word(32'h2);
    reg_write(8'h08, 32'h0000_0005);
    start_digest("R8 two n5", 64'd37);
    do_init();
    send_word(32'h7);
    reg_write(8'h08, 32'h0000_001F);
    start_digest("R8 one n31", 64'd31);
    check("R8 length holds", msg_len_o, 64'd31);

    // R9 init clears count and words
    reg_write(8'h08, 32'h0000_0009);
    do_init();
    reg_read(8'h08, rd); check("R9 count cleared", {32'd0, rd}, 64'd0);
    start_digest("R9 empty msg", 64'd0);
    send_word(32'h5);
    start_digest("R9 one after init", 64'd32);

    repeat (2) @(negedge clk);
    check("scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule